// File: doc/BRIEF.md
# Shift-Add Constant Multiplier Sequencer

This block multiplies a 32-bit integer by a small constant without a hardware multiplier. Software first writes a short program of micro-operations into an eight-slot program store. Each micro-operation forms a scaled sum, a difference or a left shift of two registers in an eight-entry register file, and writes the value into a chosen destination register. Later micro-operations can read that register. A product such as x10 takes two operations (r = 4s + s, then r = r + r). A product such as x59 takes three (t = 2s + s, then r = 2t + s, then r = 8r + t).

An operand enters through a valid/ready handshake. `in_ready` is high only while the sequencer is idle. The operand is taken on a clock edge where both `in_valid` and `in_ready` are high, and `in_valid` is ignored while a program runs. The sequencer then executes one micro-operation per cycle from slot 0. It stops at a halt operation, or after the last slot.

The result side has no back-pressure. `done` pulses for one cycle, and `result` and `ovf` keep their values until the next completion. All arithmetic wraps modulo 2^32. A sticky flag records any operation whose exact signed value left the 32-bit signed range.

Top module: `cmul_sequencer`

## Requirements
- R1: `in_ready` is 1 exactly when the sequencer is idle. An accepted operand is loaded into register 0. Registers 1 to 7 and the overflow accumulator are cleared, and execution starts at slot 0.
- R2: A micro-operation word is 17 bits: opcode [16:14], destination [13:11], source j [10:8], source k [7:5], shift amount m [4:0]. One micro-operation executes per cycle. Its result is written to the destination register and can be read by every later micro-operation.
- R3: Opcodes 0, 1, 2 and 3 compute j + k, 2j + k, 4j + k and 8j + k, modulo 2^32.
- R4: Opcode 4 computes j - k, and opcode 5 computes j shifted left by m, both modulo 2^32.
- R5: Opcode 6 (halt) ends the run and writes no register. On the next cycle `done` is 1 for exactly one cycle, `result` equals the register named by the destination field, and `in_ready` is 1. `done` is seen h+2 negative clock edges after the negative edge at which the handshake was sampled, where h is the halt's slot.
- R6: If slot 7 executes without being a halt, the run ends there as if halted. `result` is then the value that slot 7 wrote (or, if it writes nothing, its destination register), with latency 9.
- R7: Opcode 7 is a no-op: it writes no register and never sets the overflow flag.
- R8: `ovf` at `done` is 1 if, and only if, some operation of that run had an exact signed result outside [-2^31, 2^31-1]. Each new run starts with the flag cleared.
- R9: Program writes (`prog_we`) take effect only while idle. A write attempted during a run leaves the stored program unchanged.
- R10: After reset the block is idle, with `in_ready` = 1, `done` = 0, `result` = 0 and `ovf` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Program store write strobe (honoured only when idle) |
| prog_addr | input | 3 | Program slot to write |
| prog_data | input | 17 | Micro-operation word to write |
| in_valid | input | 1 | Operand valid |
| in_ready | output | 1 | Sequencer idle and able to take an operand |
| in_data | input | 32 | Operand, loaded into register 0 |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Selected register at completion, held |
| ovf | output | 1 | Signed overflow seen during the last run, held |

## Verification
The bench builds the block with its default 32-bit data width and an eight-slot program store. This makes the 2^31 signed boundary reachable with operands such as 2^29 times 5, and with a shift by 31. A full eight-operation program with no halt fits in a short run, so the implicit end of program is exercised. The bench also aims program writes and operand offers at a running sequence, checks that neither reaches the outcome, and confirms that temporaries from an earlier run are cleared.

// File: rtl/cmul_pkg.sv
package cmul_pkg;

  localparam int OPC_W  = 3;
  localparam int REG_AW = 3;
  localparam int NREG   = 1 << REG_AW;
  localparam int SH_W   = 5;
  localparam int INSN_W = OPC_W + 3 * REG_AW + SH_W;

  typedef enum logic [OPC_W-1:0] {
    OP_ADD1 = 3'd0,
    OP_ADD2 = 3'd1,
    OP_ADD4 = 3'd2,
    OP_ADD8 = 3'd3,
    OP_SUB  = 3'd4,
    OP_SHL  = 3'd5,
    OP_HALT = 3'd6,
    OP_NOP  = 3'd7
  } opcode_e;

  typedef struct packed {
    opcode_e             op;
    logic [REG_AW-1:0]   dst;
    logic [REG_AW-1:0]   srcj;
    logic [REG_AW-1:0]   srck;
    logic [SH_W-1:0]     shamt;
  } insn_t;

endpackage

// File: rtl/cmul_progmem.sv
module cmul_progmem #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 17,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] slot [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        slot[i] <= '0;
      end else if (we && waddr == AW'(i)) begin
        slot[i] <= wdata;
      end
    end
  end

  assign rdata = slot[raddr];

endmodule

// File: rtl/cmul_regfile.sv
module cmul_regfile #(
  parameter int DATA_W = 32,
  parameter int NREG   = 8,
  localparam int AW = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr_j,
  input  logic [AW-1:0]     raddr_k,
  input  logic [AW-1:0]     raddr_c,
  output logic [DATA_W-1:0] rdata_j,
  output logic [DATA_W-1:0] rdata_k,
  output logic [DATA_W-1:0] rdata_c
);

  logic [DATA_W-1:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        regs[i] <= '0;
      end else if (load) begin
        regs[i] <= (i == 0) ? load_data : '0;
      end else if (we && waddr == AW'(i)) begin
        regs[i] <= wdata;
      end
    end
  end

  assign rdata_j = regs[raddr_j];
  assign rdata_k = regs[raddr_k];
  assign rdata_c = regs[raddr_c];

  // R1
  r0_load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (regs[0] == $past(load_data)));

endmodule

// File: rtl/cmul_alu.sv
module cmul_alu
  import cmul_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  opcode_e           op,
  input  logic [DATA_W-1:0] a_j,
  input  logic [DATA_W-1:0] a_k,
  input  logic [SH_W-1:0]   shamt,
  output logic [DATA_W-1:0] res,
  output logic              writes,
  output logic              ovf
);

  localparam int EXT = 32;
  localparam int WW  = DATA_W + EXT;

  logic signed [WW-1:0] xj, xk, wide;

  assign xj = {{EXT{a_j[DATA_W-1]}}, a_j};
  assign xk = {{EXT{a_k[DATA_W-1]}}, a_k};

  always_comb begin
    unique case (op)
      OP_ADD1: wide = xj + xk;
      OP_ADD2: wide = (xj <<< 1) + xk;
      OP_ADD4: wide = (xj <<< 2) + xk;
      OP_ADD8: wide = (xj <<< 3) + xk;
      OP_SUB:  wide = xj - xk;
      OP_SHL:  wide = xj <<< shamt;
      default: wide = '0;
    endcase
  end

  assign res    = wide[DATA_W-1:0];
  assign writes = !(op == OP_HALT || op == OP_NOP);
  assign ovf    = writes && (wide != {{EXT{wide[DATA_W-1]}}, wide[DATA_W-1:0]});

endmodule

// File: rtl/cmul_sequencer.sv
module cmul_sequencer
  import cmul_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int PROG_DEPTH = 8,
  localparam int PC_W = $clog2(PROG_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prog_we,
  input  logic [PC_W-1:0]   prog_addr,
  input  logic [INSN_W-1:0] prog_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              done,
  output logic [DATA_W-1:0] result,
  output logic              ovf
);

  localparam logic [PC_W-1:0] LAST = PC_W'(PROG_DEPTH - 1);

  logic              running;
  logic [PC_W-1:0]   pc;
  logic              ovf_acc;
  logic [INSN_W-1:0] pm_rdata;
  insn_t             insn;
  logic [DATA_W-1:0] rd_j, rd_k, rd_c;
  logic [DATA_W-1:0] alu_res;
  logic              alu_writes, alu_ovf;
  logic              accept, finish;

  assign in_ready = !running;
  assign accept   = in_valid && !running;
  assign insn     = insn_t'(pm_rdata);
  assign finish   = running && (insn.op == OP_HALT || pc == LAST);

  cmul_progmem #(.DEPTH(PROG_DEPTH), .WIDTH(INSN_W)) u_prog (
    .clk   (clk),
    .rst   (rst),
    .we    (prog_we && !running),
    .waddr (prog_addr),
    .wdata (prog_data),
    .raddr (pc),
    .rdata (pm_rdata)
  );

  cmul_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .load_data (in_data),
    .we        (running && alu_writes),
    .waddr     (insn.dst),
    .wdata     (alu_res),
    .raddr_j   (insn.srcj),
    .raddr_k   (insn.srck),
    .raddr_c   (insn.dst),
    .rdata_j   (rd_j),
    .rdata_k   (rd_k),
    .rdata_c   (rd_c)
  );

  cmul_alu #(.DATA_W(DATA_W)) u_alu (
    .op     (insn.op),
    .a_j    (rd_j),
    .a_k    (rd_k),
    .shamt  (insn.shamt),
    .res    (alu_res),
    .writes (alu_writes),
    .ovf    (alu_ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      pc      <= '0;
      ovf_acc <= 1'b0;
      done    <= 1'b0;
      result  <= '0;
      ovf     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!running) begin
        if (in_valid) begin
          running <= 1'b1;
          pc      <= '0;
          ovf_acc <= 1'b0;
        end
      end else begin
        ovf_acc <= ovf_acc | alu_ovf;
        if (finish) begin
          running <= 1'b0;
          done    <= 1'b1;
          result  <= alu_writes ? alu_res : rd_c;
          ovf     <= ovf_acc | alu_ovf;
        end else begin
          pc <= pc + 1'b1;
        end
      end
    end
  end

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R5
  done_ready_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> in_ready);

  // R1
  busy_block_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  // R8
  add_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (running && insn.op == OP_ADD1 && rd_j[DATA_W-1] == rd_k[DATA_W-1]
     && alu_res[DATA_W-1] != rd_j[DATA_W-1]) |-> alu_ovf);

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (running && ovf_acc) |=> ovf_acc);

  // R7
  nop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (running && insn.op == OP_NOP) |-> (!alu_ovf && !alu_writes));

endmodule

// File: tb/tb_cmul_sequencer.sv
`timescale 1ns/1ps
module tb_cmul_sequencer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        prog_we = 1'b0;
  logic [2:0]  prog_addr = '0;
  logic [16:0] prog_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        done;
  logic [31:0] result;
  logic        ovf;

  always #2.5 clk = ~clk;

  cmul_sequencer #(.DATA_W(32), .PROG_DEPTH(8)) dut (
    .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .done(done), .result(result), .ovf(ovf)
  );

  typedef struct {
    logic [31:0] res;
    logic        ov;
    int          lat;
    string       tag;
    string       ltag;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int start_cyc = 0;
  logic [16:0] img [8];

  localparam logic [2:0] ADD1 = 3'd0, ADD2 = 3'd1, ADD4 = 3'd2, ADD8 = 3'd3,
                         SUB = 3'd4, SHL = 3'd5, HALT = 3'd6, NOP = 3'd7;

  function automatic logic [16:0] enc(input logic [2:0] op, input logic [2:0] d,
                                      input logic [2:0] j, input logic [2:0] k,
                                      input logic [4:0] m);
    return {op, d, j, k, m};
  endfunction

  task automatic check(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clear_img();
    for (int i = 0; i < 8; i++) img[i] = enc(HALT, 3'd0, 3'd0, 3'd0, 5'd0);
  endtask

  task automatic load_prog();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      prog_we = 1'b1;
      prog_addr = 3'(i);
      prog_data = img[i];
    end
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic push(input logic [31:0] r, input logic o, input int h,
                      input string tag, input string ltag);
    exp_t e;
    e.res = r; e.ov = o; e.lat = h + 2; e.tag = tag; e.ltag = ltag;
    sb.push_back(e);
  endtask

  task automatic run(input logic [31:0] s, input logic [31:0] r, input logic o,
                     input int h, input string tag, input string ltag);
    push(r, o, h, tag, ltag);
    @(negedge clk);
    in_valid = 1'b1;
    in_data = s;
    @(negedge clk);
    in_valid = 1'b0;
    while (!done) @(negedge clk);
  endtask

  // monitor: pops the scoreboard on every completion
  always @(negedge clk) begin
    cyc++;
    if (in_valid && in_ready) start_cyc = cyc;
    if (done) begin
      if (sb.size() == 0) begin
        check(1'b0, "R5 unexpected done", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(result == e.res, e.tag, result, e.res);
        check(ovf == e.ov, {e.tag, " R8 ovf"}, 32'(ovf), 32'(e.ov));
        check((cyc - start_cyc) == e.lat, e.ltag, 32'(cyc - start_cyc), 32'(e.lat));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(in_ready == 1'b1, "R10 in_ready", 32'(in_ready), 32'd1);
    check(done == 1'b0, "R10 done", 32'(done), 32'd0);
    check(result == 32'd0, "R10 result", result, 32'd0);
    check(ovf == 1'b0, "R10 ovf", 32'(ovf), 32'd0);

    // R3 x10: r1 = 4r0 + r0 ; r1 = r1 + r1 ; halt r1
    clear_img();
    img[0] = enc(ADD4, 3'd1, 3'd0, 3'd0, 5'd0);
    img[1] = enc(ADD1, 3'd1, 3'd1, 3'd1, 5'd0);
    img[2] = enc(HALT, 3'd1, 3'd0, 3'd0, 5'd0);
    load_prog();
    run(32'd7, 32'd70, 1'b0, 2, "R3 x10 of 7", "R5 latency");
    run(-32'sd3, 32'(-30), 1'b0, 2, "R3 x10 of -3", "R5 latency");
    // R8 overflow: 5 * 2^29 leaves signed range
    run(32'h2000_0000, 32'h4000_0000, 1'b1, 2, "R8 x10 wrap", "R5 latency");
    run(32'd7, 32'd70, 1'b0, 2, "R8 cleared per run", "R5 latency");

    // R1 / R9: offers and program writes while busy
    push(32'd120, 1'b0, 2, "R1 busy offer ignored", "R5 latency");
    @(negedge clk);
    in_valid = 1'b1;
    in_data = 32'd12;
    @(negedge clk);
    check(in_ready == 1'b0, "R1 in_ready while running", 32'(in_ready), 32'd0);
    in_data = 32'd99;
    prog_we = 1'b1;
    prog_addr = 3'd0;
    prog_data = enc(HALT, 3'd0, 3'd0, 3'd0, 5'd0);
    @(negedge clk);
    in_valid = 1'b0;
    prog_we = 1'b0;
    while (!done) @(negedge clk);
    run(32'd7, 32'd70, 1'b0, 2, "R9 program unchanged", "R5 latency");

    // R2 x59: r1 = 2r0 + r0 ; r2 = 2r1 + r0 ; r2 = 8r2 + r1 ; halt r2
    clear_img();
    img[0] = enc(ADD2, 3'd1, 3'd0, 3'd0, 5'd0);
    img[1] = enc(ADD2, 3'd2, 3'd1, 3'd0, 5'd0);
    img[2] = enc(ADD8, 3'd2, 3'd2, 3'd1, 5'd0);
    img[3] = enc(HALT, 3'd2, 3'd0, 3'd0, 5'd0);
    load_prog();
    run(32'd5, 32'd295, 1'b0, 3, "R2 x59 of 5", "R5 latency");
    run(32'd1000, 32'd59000, 1'b0, 3, "R2 x59 of 1000", "R5 latency");

    // R4 x15: r1 = r0 << 4 ; r2 = r1 - r0 ; halt r2
    clear_img();
    img[0] = enc(SHL, 3'd1, 3'd0, 3'd0, 5'd4);
    img[1] = enc(SUB, 3'd2, 3'd1, 3'd0, 5'd0);
    img[2] = enc(HALT, 3'd2, 3'd0, 3'd0, 5'd0);
    load_prog();
    run(32'd3, 32'd45, 1'b0, 2, "R4 shift-sub x15", "R5 latency");

    // R4 / R8 shift by 31
    clear_img();
    img[0] = enc(SHL, 3'd1, 3'd0, 3'd0, 5'd31);
    img[1] = enc(HALT, 3'd1, 3'd0, 3'd0, 5'd0);
    load_prog();
    run(32'd1, 32'h8000_0000, 1'b1, 1, "R4 shl 31 overflow", "R5 latency");
    run(32'd0, 32'd0, 1'b0, 1, "R4 shl 31 of zero", "R5 latency");

    // R6 eight doublings, no halt: result from slot 7 destination
    for (int i = 0; i < 8; i++) img[i] = enc(ADD1, 3'd0, 3'd0, 3'd0, 5'd0);
    load_prog();
    run(32'd3, 32'd768, 1'b0, 7, "R6 implicit end", "R6 latency");

    // R7 no-op aimed at r1 leaves it alone
    clear_img();
    img[0] = enc(ADD1, 3'd1, 3'd0, 3'd0, 5'd0);
    img[1] = enc(NOP, 3'd1, 3'd0, 3'd0, 5'd0);
    img[2] = enc(HALT, 3'd1, 3'd0, 3'd0, 5'd0);
    load_prog();
    run(32'd4, 32'd8, 1'b0, 2, "R7 nop no write", "R5 latency");

    // R1 temporaries cleared at start
    clear_img();
    img[0] = enc(SHL, 3'd3, 3'd0, 3'd0, 5'd1);
    img[1] = enc(HALT, 3'd3, 3'd0, 3'd0, 5'd0);
    load_prog();
    run(32'd9, 32'd18, 1'b0, 1, "R4 shl by 1", "R5 latency");
    clear_img();
    img[0] = enc(HALT, 3'd3, 3'd0, 3'd0, 5'd0);
    load_prog();
    run(32'd9, 32'd0, 1'b0, 0, "R1 r3 cleared", "R5 halt at slot 0");

    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R5 all completions seen", 32'(sb.size()), 32'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule